// File: doc/BRIEF.md
# Serial Synthesizer Control Word Loader

This block takes control words for a two-channel frequency synthesizer from a three-wire serial link. The three wires are a serial clock, a data line and a load strobe. All three inputs are resynchronized into the system clock domain. Edges of the serial clock and of the load strobe are detected there. Each rising edge of the serial clock, seen while the load strobe is low, shifts one data bit into a 23-bit collector.

A rising edge of the load strobe commits the collected word. Two address bits at the end of the word pick one of four destinations: the reference-divider settings or the feedback-divider settings of channel 0 or channel 1. The same two bits also decide how the remaining bits are read. A reference word carries a 14-bit reference ratio, a current-select bit and two test-select bits. A feedback word carries a lock-output select, a modulus select, a phase-inversion bit, a 5-bit swallow count and a 13-bit main count.

The test-select and lock-output-select bits are shared by both channels. A status output stays high until all four destinations have received a word.

Top module: `ser_cfg_loader`

## Requirements
- R1: After reset every latched field is zero and `unconfigured` is 1.
- R2: A rising edge of `ser_clk` seen while `ser_load` is low shifts the current `ser_data` bit into the collector. Only the last 23 bits shifted count. Position 1 is the last bit shifted and position 23 is the bit shifted 23rd from the end.
- R3: On a rising edge of `ser_load`, position 1 selects the channel (0 = channel 0, 1 = channel 1). Position 2 selects the word type (0 = reference word, 1 = feedback word).
- R4: Reference word fields are read as follows:
  - position 3 goes to `test_sel[0]`;
  - position 4 goes to `test_sel[1]`;
  - positions 5..18 form the ratio, with its LSB at position 5;
  - position 19 is the current select;
  - positions 20..23 are ignored.
- R5: Feedback word fields are read as follows:
  - position 3 is the lock-output select;
  - position 4 is the modulus select;
  - position 5 is the phase inversion;
  - positions 6..10 form the swallow count, with its LSB at position 6;
  - positions 11..23 form the main count, with its LSB at position 11.
- R6: A reference word whose ratio is below 3 is discarded whole. No output changes, and the word does not count toward configuration.
- R7: `test_sel` always holds the value from the most recent accepted reference word, whichever channel it addressed. `lock_sel` always holds the value from the most recent feedback word, whichever channel it addressed.
- R8: Rising edges of `ser_clk` while `ser_load` is high leave the collector unchanged, so a repeated load commits the same word again.
- R9: Latched outputs change only at a load. Shifting without a load leaves them unchanged.
- R10: `unconfigured` falls once each of the four destinations has accepted a word. After that it stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_load | input | 1 | Load strobe; rising edge commits the word |
| ch0_ratio | output | 14 | Channel 0 reference ratio |
| ch0_cur_sel | output | 1 | Channel 0 current select |
| ch0_swallow | output | 5 | Channel 0 swallow count |
| ch0_main | output | 13 | Channel 0 main count |
| ch0_mod_sel | output | 1 | Channel 0 modulus select |
| ch0_phase_inv | output | 1 | Channel 0 phase inversion |
| ch1_ratio | output | 14 | Channel 1 reference ratio |
| ch1_cur_sel | output | 1 | Channel 1 current select |
| ch1_swallow | output | 5 | Channel 1 swallow count |
| ch1_main | output | 13 | Channel 1 main count |
| ch1_mod_sel | output | 1 | Channel 1 modulus select |
| ch1_phase_inv | output | 1 | Channel 1 phase inversion |
| test_sel | output | 2 | Shared test-select bits |
| lock_sel | output | 1 | Shared lock-output select |
| unconfigured | output | 1 | High until all four destinations are written |

## Verification
The hardest situation to reach is a serial clock edge that arrives while the load strobe is already high. Such an edge is invisible at the outputs unless the same collector contents are committed a second time. The stimulus therefore commits a valid word, toggles the serial clock with changing data while the strobe stays high, and then drops and raises the strobe again. Any shift that slipped through would show up in the recommitted fields. Prohibited small ratios and over-long bit streams are mixed into random traffic, so the discard path and the 23-bit window are both exercised.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int WORD_W  = 23;
  localparam int RATIO_W = 14;
  localparam int SWAL_W  = 5;
  localparam int MAIN_W  = 13;
  localparam int NCH     = 2;
  localparam int NDEST   = 2 * NCH;

  // bit indices inside the collector (index = position - 1)
  localparam int IX_CH    = 0;
  localparam int IX_TYPE  = 1;
  localparam int IX_T1    = 2;
  localparam int IX_T2    = 3;
  localparam int IX_RATIO = 4;
  localparam int IX_CUR   = IX_RATIO + RATIO_W;
  localparam int IX_LOCK  = 2;
  localparam int IX_MOD   = 3;
  localparam int IX_POL   = 4;
  localparam int IX_SWAL  = 5;
  localparam int IX_MAIN  = IX_SWAL + SWAL_W;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               cur_sel;
  } ref_fields_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swallow;
    logic              mod_sel;
    logic              phase_inv;
  } fb_fields_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], din[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/scl_edge.sv
module scl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/scl_bank.sv
module scl_bank
  import ser_cfg_pkg::*;
#(
  parameter int MIN_RATIO = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORD_W-1:0]       word,
  output ref_fields_t [NCH-1:0]   ref_o,
  output fb_fields_t  [NCH-1:0]   fb_o,
  output logic [1:0]              test_sel,
  output logic                    lock_sel,
  output logic                    unconfigured
);
  logic               is_fb;
  logic               ratio_ok;
  logic [RATIO_W-1:0] ratio_f;
  logic [NCH-1:0]     wr_ref;
  logic [NCH-1:0]     wr_fb;
  ref_fields_t        ref_word;
  fb_fields_t         fb_word;

  always_comb begin
    is_fb    = word[IX_TYPE];
    ratio_f  = word[IX_RATIO +: RATIO_W];
    ratio_ok = (ratio_f >= RATIO_W'(MIN_RATIO));
    ref_word.ratio     = ratio_f;
    ref_word.cur_sel   = word[IX_CUR];
    fb_word.main_cnt   = word[IX_MAIN +: MAIN_W];
    fb_word.swallow    = word[IX_SWAL +: SWAL_W];
    fb_word.mod_sel    = word[IX_MOD];
    fb_word.phase_inv  = word[IX_POL];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ref_fields_t ref_q, ref_d;
    fb_fields_t  fb_q,  fb_d;

    always_comb begin
      wr_ref[c] = load && !is_fb && (word[IX_CH] == 1'(c)) && ratio_ok;
      wr_fb[c]  = load &&  is_fb && (word[IX_CH] == 1'(c));
      ref_d = ref_q;
      fb_d  = fb_q;
      if (wr_ref[c]) ref_d = ref_word;
      if (wr_fb[c])  fb_d  = fb_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q <= '0;
        fb_q  <= '0;
      end else begin
        ref_q <= ref_d;
        fb_q  <= fb_d;
      end
    end

    assign ref_o[c] = ref_q;
    assign fb_o[c]  = fb_q;
  end

  logic [1:0]       test_q, test_d;
  logic             lock_q, lock_d;
  logic [NDEST-1:0] seen_q, seen_d;

  always_comb begin
    test_d = test_q;
    lock_d = lock_q;
    if (|wr_ref) test_d = {word[IX_T2], word[IX_T1]};
    if (|wr_fb)  lock_d = word[IX_LOCK];
    seen_d = seen_q | {wr_fb, wr_ref};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
      lock_q <= 1'b0;
      seen_q <= '0;
    end else begin
      test_q <= test_d;
      lock_q <= lock_d;
      seen_q <= seen_d;
    end
  end

  assign test_sel     = test_q;
  assign lock_sel     = lock_q;
  assign unconfigured = ~&seen_q;
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RATIO   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_load,
  output logic [RATIO_W-1:0] ch0_ratio,
  output logic               ch0_cur_sel,
  output logic [SWAL_W-1:0]  ch0_swallow,
  output logic [MAIN_W-1:0]  ch0_main,
  output logic               ch0_mod_sel,
  output logic               ch0_phase_inv,
  output logic [RATIO_W-1:0] ch1_ratio,
  output logic               ch1_cur_sel,
  output logic [SWAL_W-1:0]  ch1_swallow,
  output logic [MAIN_W-1:0]  ch1_main,
  output logic               ch1_mod_sel,
  output logic               ch1_phase_inv,
  output logic [1:0]         test_sel,
  output logic               lock_sel,
  output logic               unconfigured
);
  logic [2:0]        sync_lvl;
  logic [1:0]        rise;
  logic              shift_pulse;
  logic              load_pulse;
  logic [WORD_W-1:0] sr_word;
  ref_fields_t [NCH-1:0] ref_f;
  fb_fields_t  [NCH-1:0] fb_f;

  scl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({ser_load, ser_data, ser_clk}),
    .dout(sync_lvl)
  );

  scl_edge #(.W(2)) u_edge (
    .clk (clk), .rst_n (rst_n),
    .lvl ({sync_lvl[2], sync_lvl[0]}),
    .rise(rise)
  );

  assign shift_pulse = rise[0] & ~sync_lvl[2];
  assign load_pulse  = rise[1];

  scl_shift #(.W(WORD_W)) u_shift (
    .clk (clk), .rst_n (rst_n),
    .shift_en(shift_pulse), .bit_in(sync_lvl[1]),
    .word(sr_word)
  );

  scl_bank #(.MIN_RATIO(MIN_RATIO)) u_bank (
    .clk (clk), .rst_n (rst_n),
    .load(load_pulse), .word(sr_word),
    .ref_o(ref_f), .fb_o(fb_f),
    .test_sel(test_sel), .lock_sel(lock_sel),
    .unconfigured(unconfigured)
  );

  assign ch0_ratio     = ref_f[0].ratio;
  assign ch0_cur_sel   = ref_f[0].cur_sel;
  assign ch0_swallow   = fb_f[0].swallow;
  assign ch0_main      = fb_f[0].main_cnt;
  assign ch0_mod_sel   = fb_f[0].mod_sel;
  assign ch0_phase_inv = fb_f[0].phase_inv;
  assign ch1_ratio     = ref_f[1].ratio;
  assign ch1_cur_sel   = ref_f[1].cur_sel;
  assign ch1_swallow   = fb_f[1].swallow;
  assign ch1_main      = fb_f[1].main_cnt;
  assign ch1_mod_sel   = fb_f[1].mod_sel;
  assign ch1_phase_inv = fb_f[1].phase_inv;
endmodule

// File: rtl/scl_checker.sv
module scl_checker
  import ser_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_pulse,
  input logic               shift_pulse,
  input logic [WORD_W-1:0]  sr_word,
  input logic [RATIO_W-1:0] ch0_ratio,
  input logic [RATIO_W-1:0] ch1_ratio,
  input logic [1:0]         test_sel,
  input logic               lock_sel,
  input logic               unconfigured
);
  // R9
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> ($stable(ch0_ratio) && $stable(ch1_ratio)));

  // R6
  ratio_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch0_ratio == '0) || (ch0_ratio >= RATIO_W'(3))) &&
    ((ch1_ratio == '0) || (ch1_ratio >= RATIO_W'(3))));

  // R10
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unconfigured |=> !unconfigured);

  // R8
  collector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(sr_word));

  // R7
  shared_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> ($stable(test_sel) && $stable(lock_sel)));
endmodule

bind ser_cfg_loader scl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse),
  .shift_pulse(shift_pulse), .sr_word(sr_word),
  .ch0_ratio(ch0_ratio), .ch1_ratio(ch1_ratio),
  .test_sel(test_sel), .lock_sel(lock_sel),
  .unconfigured(unconfigured)
);

// File: tb/ser_cfg_loader_test.sv
module ser_cfg_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [13:0] ch0_ratio, ch1_ratio;
  logic ch0_cur_sel, ch1_cur_sel, ch0_mod_sel, ch1_mod_sel;
  logic ch0_phase_inv, ch1_phase_inv, lock_sel, unconfigured;
  logic [4:0] ch0_swallow, ch1_swallow;
  logic [12:0] ch0_main, ch1_main;
  logic [1:0] test_sel;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // expected state
  logic [13:0] e_ratio [2];
  logic        e_cur [2];
  logic [4:0]  e_swal [2];
  logic [12:0] e_main [2];
  logic        e_mod [2];
  logic        e_pol [2];
  logic [1:0]  e_test;
  logic        e_lock;
  logic [3:0]  e_seen;

  always #2 clk = ~clk;

  ser_cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load),
    .ch0_ratio(ch0_ratio), .ch0_cur_sel(ch0_cur_sel), .ch0_swallow(ch0_swallow),
    .ch0_main(ch0_main), .ch0_mod_sel(ch0_mod_sel), .ch0_phase_inv(ch0_phase_inv),
    .ch1_ratio(ch1_ratio), .ch1_cur_sel(ch1_cur_sel), .ch1_swallow(ch1_swallow),
    .ch1_main(ch1_main), .ch1_mod_sel(ch1_mod_sel), .ch1_phase_inv(ch1_phase_inv),
    .test_sel(test_sel), .lock_sel(lock_sel), .unconfigured(unconfigured)
  );

  function automatic logic [22:0] mk_ref(input logic ch, input logic t1, input logic t2,
                                         input logic [13:0] r, input logic cs,
                                         input logic [3:0] junk);
    return {junk, cs, r, t2, t1, 1'b0, ch};
  endfunction

  function automatic logic [22:0] mk_fb(input logic ch, input logic ls, input logic sw,
                                        input logic fc, input logic [4:0] a,
                                        input logic [12:0] n);
    return {n, a, fc, sw, ls, 1'b1, ch};
  endfunction

  // bench model of a commit
  task automatic model_load(input logic [22:0] w);
    int c = w[0] ? 1 : 0;
    if (!w[1]) begin
      if (w[17:4] >= 14'd3) begin
        e_ratio[c] = w[17:4]; e_cur[c] = w[18]; e_test = {w[3], w[2]};
        e_seen[c] = 1'b1;
      end
    end else begin
      e_main[c] = w[22:10]; e_swal[c] = w[9:5]; e_mod[c] = w[3];
      e_pol[c] = w[4]; e_lock = w[2]; e_seen[2+c] = 1'b1;
    end
  endtask

  function automatic logic [72:0] exp_vec();
    return {e_main[1], e_swal[1], e_mod[1], e_pol[1], e_ratio[1], e_cur[1],
            e_main[0], e_swal[0], e_mod[0], e_pol[0], e_ratio[0], e_cur[0],
            e_test, e_lock};
  endfunction

  function automatic logic [72:0] act_vec();
    return {ch1_main, ch1_swallow, ch1_mod_sel, ch1_phase_inv, ch1_ratio, ch1_cur_sel,
            ch0_main, ch0_swallow, ch0_mod_sel, ch0_phase_inv, ch0_ratio, ch0_cur_sel,
            test_sel, lock_sel};
  endfunction

  task automatic check_fields(input string tag);
    checks++;
    if (act_vec() !== exp_vec()) begin
      errors++;
      $display("FAIL %s fields: actual=%h expected=%h", tag, act_vec(), exp_vec());
    end
  endtask

  task automatic check_cfg(input string tag);
    logic e = ~&e_seen;
    checks++;
    if (unconfigured !== e) begin
      errors++;
      $display("FAIL %s unconfigured: actual=%b expected=%b", tag, unconfigured, e);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b; ser_clk = 1'b0; wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [22:0] w, input int extra);
    for (int i = 0; i < extra; i++) shift_bit(1'($urandom_range(0, 1)));
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
    wait_clk(4);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; wait_clk(4);
    ser_load = 1'b0; wait_clk(6);
  endtask

  task automatic send(input logic [22:0] w, input int extra);
    shift_word(w, extra);
    pulse_load();
    model_load(w);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [22:0] w;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      e_ratio[c] = '0; e_cur[c] = 0; e_swal[c] = '0; e_main[c] = '0;
      e_mod[c] = 0; e_pol[c] = 0;
    end
    e_test = '0; e_lock = 0; e_seen = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    check_fields("R1"); check_cfg("R1");

    // R3 R4 lowest legal ratio on channel 0
    send(mk_ref(1'b0, 1'b1, 1'b0, 14'd3, 1'b1, 4'hA), 0);
    check_fields("R4"); check_cfg("R10");
    // R3 R4 highest ratio on channel 1
    send(mk_ref(1'b1, 1'b0, 1'b1, 14'd16383, 1'b0, 4'h5), 0);
    check_fields("R3");
    // R5 feedback words
    send(mk_fb(1'b0, 1'b1, 1'b0, 1'b1, 5'd31, 13'd8191), 0);
    check_fields("R5"); check_cfg("R10");
    send(mk_fb(1'b1, 1'b0, 1'b1, 1'b0, 5'd6, 13'd3), 0);
    check_fields("R5"); check_cfg("R10");

    // R6 prohibited ratios are dropped
    send(mk_ref(1'b0, 1'b0, 1'b1, 14'd2, 1'b0, 4'h0), 0);
    check_fields("R6");
    send(mk_ref(1'b1, 1'b1, 1'b1, 14'd0, 1'b1, 4'hF), 0);
    check_fields("R6");

    // R7 shared fields follow the most recent word of their kind
    send(mk_ref(1'b1, 1'b1, 1'b1, 14'd100, 1'b1, 4'h3), 0);
    send(mk_fb(1'b0, 1'b0, 1'b1, 1'b1, 5'd9, 13'd77), 0);
    check_fields("R7");

    // R2 long stream: only the final 23 bits count
    send(mk_fb(1'b1, 1'b1, 1'b0, 1'b1, 5'd17, 13'd4000), 9);
    check_fields("R2");

    // R9 shifting without a load changes nothing
    shift_word(mk_ref(1'b0, 1'b0, 1'b0, 14'd555, 1'b0, 4'h1), 0);
    check_fields("R9");

    // R8 serial clocks while load is high are ignored, reload gives same word
    w = mk_ref(1'b0, 1'b1, 1'b0, 14'd1234, 1'b1, 4'h0);
    shift_word(w, 0);
    ser_load = 1'b1; wait_clk(4);
    for (int i = 0; i < 10; i++) shift_bit(1'(i % 2));
    ser_load = 1'b0; wait_clk(6);
    model_load(w);
    check_fields("R8");
    e_ratio[0] = e_ratio[0];
    pulse_load();
    model_load(w);
    check_fields("R8");

    // random traffic
    for (int k = 0; k < 40; k++) begin
      logic ch = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 0) begin
        logic [13:0] r = ($urandom_range(0, 5) == 0) ? 14'($urandom_range(0, 3))
                                                      : 14'($urandom_range(0, 16383));
        w = mk_ref(ch, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), r,
                   1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      end else begin
        w = mk_fb(ch, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                  13'($urandom_range(0, 8191)));
      end
      send(w, int'($urandom_range(0, 4)));
      check_fields(w[1] ? "R5" : "R4");
      check_cfg("R10");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule